// File: doc/BRIEF.md
# Micro-Step Memory Write Sequencer

This block sits outside the processor and performs a single memory write by driving the processor's micro-control selects directly. No program in the CPU takes part. A one-cycle start request captures an address word and a data word. The sequencer then runs a fixed order of micro-steps:

1. It loads the memory address register from the shared data output.
2. It raises the memory request strobe, only after the address load.
3. It loads the memory data register over the same path.
4. It raises the write request strobe as the last step.

The write request strobe stays high until memory acknowledges. The sequencer then reports completion and goes back to idle.

Every register load drives three things together, for one cycle: the source-B enable, the three-bit source-B select, and a destination strobe. The number of cycles from the address load to the memory request is the parameter `REQ_GAP`, which must be at least 1. Any start request seen while a sequence is running is dropped.

Top module: `mem_write_seq`

## Requirements
- R1: While rst_ni is low, every strobe, enable and select output is 0, bus_o is 0, and busy_o and done_o are 0.
- R2: A start_i sampled high in idle makes the next cycle the address load. In that cycle ld_mar_o=1, src_en_o=1, src_sel_o=SRC_CODE and bus_o holds addr_i zero-extended to DW bits. ld_mar_o lasts exactly one cycle.
- R3: mem_req_o is high for exactly one cycle, exactly REQ_GAP cycles after the address-load cycle, and never without a preceding address load.
- R4: The cycle after mem_req_o is the data load: ld_mdr_o=1, src_en_o=1, src_sel_o=SRC_CODE, and bus_o holds the captured data word, for one cycle.
- R5: wr_req_o rises in the cycle after the data load and stays high until mem_ack_i is sampled high. mem_ack_i has no effect in any other phase.
- R6: The cycle after mem_ack_i is sampled high with wr_req_o high, done_o=1 for one cycle, wr_req_o=0 and busy_o=1. The cycle after that, busy_o=0.
- R7: start_i is ignored while busy_o is high. Changes to addr_i and data_i after the accepted start do not change the words placed on bus_o.
- R8: busy_o is high from the cycle after the accepted start through the done cycle, and low otherwise.
- R9: At most one of ld_mar_o, ld_mdr_o, mem_req_o and wr_req_o is high in any cycle. bus_o and src_sel_o are 0 whenever src_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; captures addr_i and data_i |
| addr_i | input | AW | Memory address for the write |
| data_i | input | DW | Word to write |
| mem_ack_i | input | 1 | Memory acknowledge that ends the write request |
| src_en_o | output | 1 | Source-B enable |
| src_sel_o | output | 3 | Source-B select code |
| ld_mar_o | output | 1 | Destination strobe: load memory address register |
| ld_mdr_o | output | 1 | Destination strobe: load memory data register |
| bus_o | output | DW | Shared data output |
| mem_req_o | output | 1 | Memory request strobe |
| wr_req_o | output | 1 | Write request strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases are the stray inputs that arrive while a sequence is in flight. These are start requests, new address and data words, and acknowledges that come before the write request. Each can corrupt a sequence only if it lands in one particular phase.

The bench sweeps many address and data words against every acknowledge delay from zero to three cycles. Half of the sequences are poked during the address load and the wait cycles: start_i is held high, addr_i and data_i are inverted, and mem_ack_i is asserted. A start is also held across the done cycle.

A reset taken while the write request is pending confirms that all outputs clear at once.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_MAR,
    ST_WAIT,
    ST_MREQ,
    ST_LD_MDR,
    ST_WREQ,
    ST_DONE
  } mws_state_e;
endpackage

// File: rtl/mws_gap_cnt.sv
module mws_gap_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
#(
  parameter int unsigned REQ_GAP = 3,
  parameter int unsigned GAP_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mem_ack_i,
  input  logic             gap_zero_i,
  output mws_state_e       state_o,
  output logic             capture_o,
  output logic             gap_load_o,
  output logic [GAP_W-1:0] gap_load_val_o,
  output logic             gap_dec_o
);
  localparam int unsigned WAIT_CYC = REQ_GAP - 1;
  localparam int unsigned LOAD_VAL = (REQ_GAP > 1) ? REQ_GAP - 2 : 0;

  mws_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    capture_o  = 1'b0;
    gap_load_o = 1'b0;
    gap_dec_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        capture_o = 1'b1;
        state_d   = ST_LD_MAR;
      end
      ST_LD_MAR: begin
        gap_load_o = 1'b1;
        state_d    = (WAIT_CYC == 0) ? ST_MREQ : ST_WAIT;
      end
      ST_WAIT: begin
        // leave after exactly REQ_GAP-1 wait cycles
        if (gap_zero_i) state_d = ST_MREQ;
        else            gap_dec_o = 1'b1;
      end
      ST_MREQ:   state_d = ST_LD_MDR;
      ST_LD_MDR: state_d = ST_WREQ;
      ST_WREQ:   if (mem_ack_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o        = state_q;
  assign gap_load_val_o = GAP_W'(LOAD_VAL);
endmodule

// File: rtl/mws_outdec.sv
module mws_outdec
  import mws_pkg::*;
#(
  parameter int unsigned SRC_W    = 3,
  parameter logic [SRC_W-1:0] SRC_CODE = 3'd5
) (
  input  mws_state_e       state_i,
  output logic             ld_mar_o,
  output logic             ld_mdr_o,
  output logic             mem_req_o,
  output logic             wr_req_o,
  output logic             src_en_o,
  output logic [SRC_W-1:0] src_sel_o,
  output logic             busy_o,
  output logic             done_o
);
  always_comb begin
    ld_mar_o  = (state_i == ST_LD_MAR);
    ld_mdr_o  = (state_i == ST_LD_MDR);
    mem_req_o = (state_i == ST_MREQ);
    wr_req_o  = (state_i == ST_WREQ);
    done_o    = (state_i == ST_DONE);
    busy_o    = (state_i != ST_IDLE);
    src_en_o  = ld_mar_o | ld_mdr_o;
    src_sel_o = src_en_o ? SRC_CODE : '0;
  end
endmodule

// File: rtl/mws_datapath.sv
module mws_datapath #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          sel_addr_i,
  input  logic          sel_data_i,
  output logic [DW-1:0] bus_o
);
  logic [DW-1:0] addr_ext, addr_q, data_q;

  generate
    if (AW == DW) begin : g_addr_full
      assign addr_ext = addr_i;
    end else begin : g_addr_pad
      assign addr_ext = {{(DW-AW){1'b0}}, addr_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture_i) begin
      addr_q <= addr_ext;
      data_q <= data_i;
    end
  end

  always_comb begin
    bus_o = '0;
    if (sel_addr_i)      bus_o = addr_q;
    else if (sel_data_i) bus_o = data_q;
  end
endmodule

// File: rtl/mem_write_seq.sv
module mem_write_seq
  import mws_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 16,
  parameter int unsigned REQ_GAP  = 3,
  parameter logic [2:0]  SRC_CODE = 3'd5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          mem_ack_i,
  output logic          src_en_o,
  output logic [2:0]    src_sel_o,
  output logic          ld_mar_o,
  output logic          ld_mdr_o,
  output logic [DW-1:0] bus_o,
  output logic          mem_req_o,
  output logic          wr_req_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned GAP_W = (REQ_GAP < 2) ? 1 : $clog2(REQ_GAP);

  mws_state_e       state;
  logic             capture, gap_load, gap_dec, gap_zero;
  logic [GAP_W-1:0] gap_load_val;

  mws_ctrl #(.REQ_GAP(REQ_GAP), .GAP_W(GAP_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .mem_ack_i      (mem_ack_i),
    .gap_zero_i     (gap_zero),
    .state_o        (state),
    .capture_o      (capture),
    .gap_load_o     (gap_load),
    .gap_load_val_o (gap_load_val),
    .gap_dec_o      (gap_dec)
  );

  mws_gap_cnt #(.W(GAP_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (gap_load),
    .load_val_i (gap_load_val),
    .dec_i      (gap_dec),
    .zero_o     (gap_zero)
  );

  mws_outdec #(.SRC_W(3), .SRC_CODE(SRC_CODE)) u_dec (
    .state_i   (state),
    .ld_mar_o  (ld_mar_o),
    .ld_mdr_o  (ld_mdr_o),
    .mem_req_o (mem_req_o),
    .wr_req_o  (wr_req_o),
    .src_en_o  (src_en_o),
    .src_sel_o (src_sel_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  mws_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .sel_addr_i (ld_mar_o),
    .sel_data_i (ld_mdr_o),
    .bus_o      (bus_o)
  );
endmodule

// File: rtl/mem_write_seq_chk.sv
module mem_write_seq_chk #(
  parameter int unsigned DW      = 16,
  parameter int unsigned REQ_GAP = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          mem_ack_i,
  input logic          src_en_o,
  input logic [2:0]    src_sel_o,
  input logic          ld_mar_o,
  input logic          ld_mdr_o,
  input logic [DW-1:0] bus_o,
  input logic          mem_req_o,
  input logic          wr_req_o,
  input logic          busy_o,
  input logic          done_o
);
  // cycles since the last address load, saturating
  logic [15:0] since_mar;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   since_mar <= '0;
    else if (ld_mar_o)             since_mar <= 16'd1;
    else if (mem_req_o)            since_mar <= '0;
    else if (since_mar != '0 && since_mar != 16'hFFFF) since_mar <= since_mar + 16'd1;
  end

  p_start_r2:     assert property (@(posedge clk_i) disable iff (!rst_ni) (!busy_o && start_i) |=> ld_mar_o);
  p_mar_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) ld_mar_o |=> !ld_mar_o);
  p_req_gap_r3:   assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |-> (since_mar == 16'(REQ_GAP)));
  p_mdr_next_r4:  assert property (@(posedge clk_i) disable iff (!rst_ni) mem_req_o |=> (ld_mdr_o && !mem_req_o));
  p_wr_next_r5:   assert property (@(posedge clk_i) disable iff (!rst_ni) ld_mdr_o |=> wr_req_o);
  p_wr_hold_r5:   assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_o && !mem_ack_i) |=> wr_req_o);
  p_done_r6:      assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_o && mem_ack_i) |=> (done_o && !wr_req_o && busy_o));
  p_idle_r6:      assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !busy_o);
  p_busy_r8:      assert property (@(posedge clk_i) disable iff (!rst_ni) (ld_mar_o || ld_mdr_o || mem_req_o || wr_req_o || done_o) |-> busy_o);
  p_onehot_r9:    assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({ld_mar_o, ld_mdr_o, mem_req_o, wr_req_o}));
  p_quiet_r9:     assert property (@(posedge clk_i) disable iff (!rst_ni) !src_en_o |-> (bus_o == '0 && src_sel_o == '0));
endmodule

bind mem_write_seq mem_write_seq_chk #(.DW(DW), .REQ_GAP(REQ_GAP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mem_ack_i (mem_ack_i),
  .src_en_o  (src_en_o),
  .src_sel_o (src_sel_o),
  .ld_mar_o  (ld_mar_o),
  .ld_mdr_o  (ld_mdr_o),
  .bus_o     (bus_o),
  .mem_req_o (mem_req_o),
  .wr_req_o  (wr_req_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_mem_write_seq.sv
module test_mem_write_seq;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 16;
  localparam int unsigned G  = 3;
  localparam logic [2:0]  SC = 3'd5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic          mem_ack_i = 1'b0;
  logic          src_en_o, ld_mar_o, ld_mdr_o, mem_req_o, wr_req_o, busy_o, done_o;
  logic [2:0]    src_sel_o;
  logic [DW-1:0] bus_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mem_write_seq #(.AW(AW), .DW(DW), .REQ_GAP(G), .SRC_CODE(SC)) i_mem_write_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .mem_ack_i(mem_ack_i), .src_en_o(src_en_o), .src_sel_o(src_sel_o), .ld_mar_o(ld_mar_o),
    .ld_mdr_o(ld_mdr_o), .bus_o(bus_o), .mem_req_o(mem_req_o), .wr_req_o(wr_req_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ctl = {ld_mar, ld_mdr, mem_req, wr_req, src_en, busy, done}
  task automatic expect_cycle(input string tag, input logic [6:0] ctl, input logic [DW-1:0] bus);
    chk({tag, " ctl"}, 32'({ld_mar_o, ld_mdr_o, mem_req_o, wr_req_o, src_en_o, busy_o, done_o}), 32'(ctl));
    chk({tag, " bus"}, 32'(bus_o), 32'(bus));
    chk({tag, " sel"}, 32'(src_sel_o), ctl[2] ? 32'(SC) : 32'd0);
  endtask

  task automatic run_seq(input logic [AW-1:0] a, input logic [DW-1:0] d, input int ack_dly, input bit poke);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = poke; mem_ack_i = poke;
    if (poke) begin addr_i = ~a; data_i = ~d; end
    expect_cycle("R2 mar", 7'b1000110, {{(DW-AW){1'b0}}, a});
    for (int k = 2; k <= G; k++) begin
      @(negedge clk);
      expect_cycle("R3 wait R7", 7'b0000010, '0);
    end
    @(negedge clk);
    start_i = 1'b0; mem_ack_i = 1'b0;
    expect_cycle("R3 mreq", 7'b0010010, '0);
    @(negedge clk);
    expect_cycle("R4 mdr R7", 7'b0100110, d);
    for (int j = 0; j <= ack_dly; j++) begin
      @(negedge clk);
      expect_cycle("R5 wr hold", 7'b0001010, '0);
      mem_ack_i = (j == ack_dly);
    end
    @(negedge clk);
    mem_ack_i = 1'b0;
    start_i = poke;
    expect_cycle("R6 done R8", 7'b0000011, '0);
    @(negedge clk);
    start_i = 1'b0;
    expect_cycle("R6 idle R8", 7'b0000000, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #5;
    expect_cycle("R1 reset", 7'b0000000, '0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_cycle("R1 after reset", 7'b0000000, '0);

    for (int i = 0; i < 16; i++) begin
      for (int dly = 0; dly < 4; dly++) begin
        for (int p = 0; p < 2; p++) begin
          logic [AW-1:0] a;
          logic [DW-1:0] d;
          a = AW'(i * 273 + dly * 1024 + p * 7);
          d = DW'(i * 4369) ^ DW'(dly * 40961 + p);
          run_seq(a, d, dly, p[0]);
        end
      end
    end

    // R1: asynchronous reset while the write request is pending
    @(negedge clk);
    start_i = 1'b1; addr_i = 12'hABC; data_i = 16'h1234;
    @(negedge clk);
    start_i = 1'b0;
    repeat (G + 2) @(negedge clk);
    expect_cycle("R5 pre-reset", 7'b0001010, '0);
    rst_ni = 1'b0;
    #1;
    expect_cycle("R1 mid reset", 7'b0000000, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    expect_cycle("R1 idle after reset", 7'b0000000, '0);
    run_seq(12'hFFF, 16'hFFFF, 2, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule